// File: doc/BRIEF.md
# Memory-Playback Video Address Sequencer

This block streams a complete pre-rendered video frame out of an external byte-wide asynchronous SRAM. The frame is stored whole, so the blanking intervals and the sync pulses sit in memory alongside the visible pixels. The block issues one linear read address on every dot clock. It then registers the returned byte into separate colour fields and horizontal and vertical sync outputs.

No horizontal or vertical counters and no timing comparators are used. The block has a single flat address counter. That counter goes back to zero when the stored vertical-sync bit falls, so the memory contents alone set the frame length. A 640x480 frame of 800 by 525 dot clocks uses 420000 addresses. A test frame of only eight dots replays just as well.

Each stored byte carries blue in bits [1:0], green in bits [3:2], red in bits [5:4], horizontal sync in bit 6 and vertical sync in bit 7. A stored 1 means the sync is asserted, and the sync outputs are active high.

Top module: `vid_playback_seq`

## Requirements
- R1: While rst_n is low, sram_addr is 0, red, grn and blu are 0, and hsync and vsync are 0.
- R2: When no restart occurs at a rising clock edge, sram_addr increases by exactly one at that edge.
- R3: A restart occurs at an edge where the byte currently read has bit 7 = 0 and vsync (the registered bit 7 of the previous byte) is 1. sram_addr is 0 after that edge.
- R4: One clock after an address is issued, red, grn and blu hold bits [5:4], [3:2] and [1:0] of the byte read at that address.
- R5: One clock after an address is issued, hsync holds bit 6 and vsync holds bit 7 of the byte read at that address.
- R6: When memory holds no falling vertical-sync marker, the address wraps from 2^ADDR_W-1 to 0 and keeps counting.
- R7: A frame of 8 dots, with bit 7 set only at address 6, replays continuously with sram_addr cycling 0,1,...,7,0.
- R8: After reset the previous-sync state is cleared, so the first byte read cannot trigger a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sram_addr | output | ADDR_W | Read address to the SRAM |
| sram_data | input | 8 | Byte returned by the SRAM for sram_addr |
| red | output | 2 | Registered red field |
| grn | output | 2 | Registered green field |
| blu | output | 2 | Registered blue field |
| hsync | output | 1 | Registered horizontal sync, active high |
| vsync | output | 1 | Registered vertical sync, active high |

## Verification
The bench builds the block with ADDR_W = 8, so the address space is 256 locations. This makes the natural wrap from 255 to 0 reachable within a few hundred clocks, and the bench memory can cover the whole space. Random frames with lengths from 3 to 200 dots and random vertical-sync bits test the restart rule against many marker positions, including back-to-back markers. Directed runs cover the eight-dot frame, a memory with no falling marker, and a memory with the sync bit held high everywhere.

// File: rtl/vps_pkg.sv
package vps_pkg;
  localparam int BYTE_W  = 8;
  localparam int FIELD_W = 2;
  localparam int HS_BIT  = 6;
  localparam int VS_BIT  = 7;

  typedef struct packed {
    logic               vs;
    logic               hs;
    logic [FIELD_W-1:0] r;
    logic [FIELD_W-1:0] g;
    logic [FIELD_W-1:0] b;
  } vps_word_t;
endpackage

// File: rtl/vps_restart_det.sv
module vps_restart_det (
  input  logic vs_now,
  input  logic vs_prev,
  output logic restart
);
  // Trailing edge of the stored vertical-sync marker ends the frame.
  always_comb begin
    restart = vs_prev & ~vs_now;
  end
endmodule

// File: rtl/vps_addr_ctr.sv
module vps_addr_ctr #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    if (restart) addr_d = '0;
    else         addr_d = addr_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/vps_out_reg.sv
module vps_out_reg
  import vps_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  vps_word_t          word_in,
  output logic [FIELD_W-1:0] red,
  output logic [FIELD_W-1:0] grn,
  output logic [FIELD_W-1:0] blu,
  output logic               hsync,
  output logic               vsync
);
  vps_word_t word_q;
  vps_word_t word_d;

  always_comb begin
    word_d = word_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign red   = word_q.r;
  assign grn   = word_q.g;
  assign blu   = word_q.b;
  assign hsync = word_q.hs;
  assign vsync = word_q.vs;
endmodule

// File: rtl/vid_playback_seq.sv
module vid_playback_seq
  import vps_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] sram_addr,
  input  logic [7:0]        sram_data,
  output logic [1:0]        red,
  output logic [1:0]        grn,
  output logic [1:0]        blu,
  output logic              hsync,
  output logic              vsync
);
  vps_word_t word;
  logic      restart;

  assign word = vps_word_t'(sram_data);

  vps_restart_det u_det (
    .vs_now  (word.vs),
    .vs_prev (vsync),
    .restart (restart)
  );

  vps_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .addr    (sram_addr)
  );

  vps_out_reg u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .word_in (word),
    .red     (red),
    .grn     (grn),
    .blu     (blu),
    .hsync   (hsync),
    .vsync   (vsync)
  );
endmodule

// File: rtl/vps_checker.sv
module vps_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [7:0]        sram_data,
  input logic [1:0]        red,
  input logic [1:0]        grn,
  input logic [1:0]        blu,
  input logic              hsync,
  input logic              vsync
);
  // R1: reset state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_state: assert (sram_addr == '0 && red == 2'd0 && grn == 2'd0
                                && blu == 2'd0 && !hsync && !vsync);
    end
  end

  // R2, R6: step by one, wrapping at the top of the address space
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(vsync && !sram_data[7]) |=> sram_addr == $past(sram_addr) + ADDR_W'(1));

  // R3: falling stored vertical sync restarts at address 0
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && !sram_data[7]) |=> sram_addr == '0);

  // R4: colour fields one clock after the address
  a_r4_colour: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> {red, grn, blu} == $past(sram_data[5:0]));

  // R5: sync bits one clock after the address
  a_r5_sync: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hsync == $past(sram_data[6])) && (vsync == $past(sram_data[7])));
endmodule

bind vid_playback_seq vps_checker #(.ADDR_W(ADDR_W)) u_vps_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sram_addr (sram_addr),
  .sram_data (sram_data),
  .red       (red),
  .grn       (grn),
  .blu       (blu),
  .hsync     (hsync),
  .vsync     (vsync)
);

// File: tb/vid_playback_seq_test.sv
module vid_playback_seq_test;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] sram_addr;
  logic [7:0]    sram_data;
  logic [1:0]    red, grn, blu;
  logic          hsync, vsync;

  logic [7:0] mem [DEPTH];
  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [AW-1:0] exp_addr;
  logic [7:0]    exp_out;

  always #5 clk = ~clk;

  assign sram_data = mem[sram_addr];

  vid_playback_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .sram_addr(sram_addr), .sram_data(sram_data),
    .red(red), .grn(grn), .blu(blu), .hsync(hsync), .vsync(vsync)
  );

  function automatic logic [AW-1:0] next_addr(logic [AW-1:0] a, logic prev_vs,
                                              logic cur_vs);
    if (prev_vs && !cur_vs) return '0;
    return a + AW'(1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1", {sram_addr, red, grn, blu, hsync, vsync}, '0);
    rst_n = 1'b1;
    exp_addr = '0;
    exp_out  = 8'h00;
  endtask

  // Compare the outputs at a negedge, then advance the model by one edge.
  task automatic run(int n, bit tag_r7, bit tag_r6);
    for (int i = 0; i < n; i++) begin
      logic prev_vs;
      logic [AW-1:0] nxt;
      check((exp_addr == '0 && i > 0) ? "R3/R2 addr" : "R2 addr",
            sram_addr, exp_addr);
      check("R4 colour", {red, grn, blu}, exp_out[5:0]);
      check("R5 sync", {hsync, vsync}, {exp_out[6], exp_out[7]});
      if (tag_r7) check("R7 short frame", sram_addr, i % 8);
      if (tag_r6 && i == DEPTH) check("R6 wrap", sram_addr, 0);
      prev_vs  = exp_out[7];
      nxt      = next_addr(exp_addr, prev_vs, mem[exp_addr][7]);
      exp_out  = mem[exp_addr];
      exp_addr = nxt;
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);

    // R7, R8: eight-dot frame, marker only at address 6
    for (int a = 0; a < DEPTH; a++) mem[a] = 8'($urandom) & 8'h7f;
    mem[6] = mem[6] | 8'h80;
    do_reset();
    run(40, 1'b1, 1'b0);

    // R8: byte 0 with sync clear after reset must not restart
    for (int a = 0; a < DEPTH; a++) mem[a] = 8'($urandom) & 8'h7f;
    mem[0] = 8'h15;
    mem[1] = 8'h2a;
    do_reset();
    check("R8 first byte", sram_addr, 0);
    @(negedge clk);
    check("R8 no early restart", sram_addr, 1);
    exp_addr = 8'd1; exp_out = 8'h15;
    run(10, 1'b0, 1'b0);

    // R6: no marker at all, natural wrap
    for (int a = 0; a < DEPTH; a++) mem[a] = 8'($urandom) & 8'h7f;
    do_reset();
    run(DEPTH + 20, 1'b0, 1'b1);

    // R6: sync high everywhere, never falls
    for (int a = 0; a < DEPTH; a++) mem[a] = 8'($urandom) | 8'h80;
    do_reset();
    run(DEPTH + 20, 1'b0, 1'b1);

    // R3: random frame lengths, marker just before the last dot
    for (int t = 0; t < 12; t++) begin
      int len = 3 + int'($urandom % 198);
      for (int a = 0; a < DEPTH; a++) mem[a] = 8'($urandom) & 8'h7f;
      mem[len-2] = mem[len-2] | 8'h80;
      if (len > 4 && ($urandom % 2) == 1) mem[len-3] = mem[len-3] | 8'h80;
      do_reset();
      run(3 * len + 10, 1'b0, 1'b0);
    end

    // R2, R3: fully random sync bits
    for (int t = 0; t < 6; t++) begin
      for (int a = 0; a < DEPTH; a++) mem[a] = 8'($urandom);
      do_reset();
      run(600, 1'b0, 1'b0);
    end

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule